// File: doc/BRIEF.md
# Synchronous-Frame Harmonic Current Reference Extractor

This block computes the three per-phase compensating current commands for a shunt active filter. Each time a sample strobe arrives, it takes three load current samples, the sine and cosine of the grid angle (supplied by an external angle tracker), and a DC-link loss current term. The block projects the load currents onto two stationary axes. It then rotates that pair into a frame that turns with the grid. The direct-axis component goes through a first-order low-pass filter, so only its steady part is kept.

The loss term is added to the filtered direct-axis value, and the quadrature reference is zero. The result is rotated back and expanded into three phase references. Each output is the phase reference minus the same sample's load current, so the outputs carry the harmonic and reactive content that the filter must inject. The datapath uses signed Q1.15 numbers throughout and has a fixed pipeline latency. A sample can be accepted on every clock cycle.

Top module: `harmRefTop`

## Requirements
- R1: While reset is low, `outValid` is 0 and all three compensation outputs are 0. Reset sets the filter state to 0, so the first sample after reset filters from a state of zero.
- R2: `outValid` is high for exactly one cycle per accepted strobe. That cycle is the 6th rising edge after the edge that sampled the strobe. Strobes on consecutive cycles give outputs on consecutive cycles, in the same order.
- R3: Stationary projection: alpha = sat(((2a - b - c) * 26755) >>> 16) and beta = sat(((b - c) * 23170) >>> 15). Here a, b and c are the load samples read as signed Q1.15.
- R4: Rotation: d = sat((sin * alpha - cos * beta) >>> 15).
- R5: Filter: y = sat(y + ((d - y) >>> k)). The shift k is the 4-bit `filtShift` value captured with the same strobe. With k = 0, y equals d. y changes only when a strobe is accepted.
- R6: The direct-axis reference is dRef = sat(y + loss), using the updated y. The quadrature reference is 0.
- R7: Inverse rotation: alphaR = sat((sin * dRef) >>> 15) and betaR = sat((-(cos * dRef)) >>> 15).
- R8: Phase references: refA = sat((alphaR * 26755) >>> 15), refB = sat((betaR * 23170 - alphaR * 13378) >>> 15) and refC = sat((-(alphaR * 13378) - betaR * 23170) >>> 15).
- R9: Each output is compX = sat(refX - loadX), where loadX is the load sample of the same strobe.
- R10: Every sat() above clamps to the range [-32768, 32767] and never wraps. Shifts are arithmetic (floor).
- R11: Inputs on cycles without a strobe have no effect. The outputs hold their values between valid pulses, and the filter state does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStrobe | input | 1 | Accept the current input set |
| loadA | input | 16 | Phase A load current, signed Q1.15 |
| loadB | input | 16 | Phase B load current, signed Q1.15 |
| loadC | input | 16 | Phase C load current, signed Q1.15 |
| sinTheta | input | 16 | Sine of grid angle, signed Q1.15 |
| cosTheta | input | 16 | Cosine of grid angle, signed Q1.15 |
| lossCur | input | 16 | DC-link loss current term, signed Q1.15 |
| filtShift | input | 4 | Low-pass shift k for this sample |
| outValid | output | 1 | One-cycle pulse marking new outputs |
| compA | output | 16 | Phase A compensation current |
| compB | output | 16 | Phase B compensation current |
| compC | output | 16 | Phase C compensation current |

## Verification
On every cycle, the assertions check the handshake. Each strobe yields a valid pulse six edges later, no pulse appears without a strobe in flight, and the number in flight never exceeds the pipeline depth. They also check that the outputs stay frozen whenever no pulse is present and that reset holds everything at zero. The numerical chain cannot be seen by a property: the saturating projections, the filter's dependence on earlier samples and on k, the loss offset and the pairing of each reference with its own load sample. The bench scenarios show these by comparing every output against an independent fixed-point model, including saturated inputs, k = 0 and k = 15, ignored input activity between strobes, and back-to-back bursts.

// File: rtl/harmRefPkg.sv
package harmRefPkg;
  localparam int DW      = 16;
  localparam int ACC_W   = 40;
  localparam int FRAC    = DW - 1;
  localparam int STAGES  = 6;

  typedef logic signed [DW-1:0]    sample_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam longint MAX_POS = (64'sd1 <<< (DW - 1)) - 64'sd1;
  localparam longint MIN_NEG = -(64'sd1 <<< (DW - 1));

  // Q1.15 coefficients: sqrt(2/3), sqrt(2/3)/2, sqrt(2/3)*sqrt(3)/2
  localparam acc_t K_FULL = acc_t'(26755);
  localparam acc_t K_HALF = acc_t'(13378);
  localparam acc_t K_ROOT = acc_t'(23170);

  typedef struct packed {
    logic s1;
    logic s2;
    logic s3;
    logic s4;
    logic s5;
    logic s6;
  } stageEn_t;

  function automatic acc_t ext(input sample_t x);
    return acc_t'(x);
  endfunction

  function automatic sample_t sat(input acc_t v);
    if (v > acc_t'(MAX_POS)) return sample_t'(MAX_POS);
    if (v < acc_t'(MIN_NEG)) return sample_t'(MIN_NEG);
    return sample_t'(v);
  endfunction
endpackage

// File: rtl/harmRefCtrl.sv
module harmRefCtrl
  import harmRefPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleStrobe,
  output stageEn_t stageEn,
  output logic     outValid
);
  logic [STAGES-1:0] vld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vld <= '0;
    else       vld <= {vld[STAGES-2:0], sampleStrobe};
  end

  always_comb begin
    stageEn.s1 = sampleStrobe;
    stageEn.s2 = vld[0];
    stageEn.s3 = vld[1];
    stageEn.s4 = vld[2];
    stageEn.s5 = vld[3];
    stageEn.s6 = vld[4];
  end

  assign outValid = vld[STAGES-1];
endmodule

// File: rtl/harmRefDatapath.sv
module harmRefDatapath
  import harmRefPkg::*;
#(
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  stageEn_t           stageEn,
  input  sample_t            loadA,
  input  sample_t            loadB,
  input  sample_t            loadC,
  input  sample_t            sinTheta,
  input  sample_t            cosTheta,
  input  sample_t            lossCur,
  input  logic [SHIFT_W-1:0] filtShift,
  output sample_t            compA,
  output sample_t            compB,
  output sample_t            compC
);
  // phase-sample carry chain, one slot per stage 1..5
  sample_t ldA [1:5];
  sample_t ldB [1:5];
  sample_t ldC [1:5];

  // stage 1: stationary projection
  sample_t alpha1, beta1, sin1, cos1, loss1;
  logic [SHIFT_W-1:0] k1;
  acc_t sumAlpha, prodAlpha, prodBeta;

  always_comb begin
    sumAlpha  = (ext(loadA) <<< 1) - ext(loadB) - ext(loadC);
    prodAlpha = sumAlpha * K_FULL;
    prodBeta  = (ext(loadB) - ext(loadC)) * K_ROOT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alpha1 <= '0; beta1 <= '0; sin1 <= '0; cos1 <= '0; loss1 <= '0; k1 <= '0;
    end else if (stageEn.s1) begin
      alpha1 <= sat(prodAlpha >>> (FRAC + 1));
      beta1  <= sat(prodBeta >>> FRAC);
      sin1   <= sinTheta;
      cos1   <= cosTheta;
      loss1  <= lossCur;
      k1     <= filtShift;
    end
  end

  // stage 2: rotation onto the direct axis
  sample_t dAxis2, sin2, cos2, loss2;
  logic [SHIFT_W-1:0] k2;
  acc_t rotSum;

  always_comb rotSum = ext(sin1) * ext(alpha1) - ext(cos1) * ext(beta1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dAxis2 <= '0; sin2 <= '0; cos2 <= '0; loss2 <= '0; k2 <= '0;
    end else if (stageEn.s2) begin
      dAxis2 <= sat(rotSum >>> FRAC);
      sin2   <= sin1;
      cos2   <= cos1;
      loss2  <= loss1;
      k2     <= k1;
    end
  end

  // stage 3: first-order low-pass of the direct axis, plus loss term
  sample_t filtState, dRef3, sin3, cos3, yNext;
  acc_t diff;

  always_comb begin
    diff  = ext(dAxis2) - ext(filtState);
    yNext = sat(ext(filtState) + (diff >>> k2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtState <= '0; dRef3 <= '0; sin3 <= '0; cos3 <= '0;
    end else if (stageEn.s3) begin
      filtState <= yNext;
      dRef3     <= sat(ext(yNext) + ext(loss2));
      sin3      <= sin2;
      cos3      <= cos2;
    end
  end

  // stage 4: inverse rotation with zero quadrature reference
  sample_t alphaR4, betaR4;
  acc_t prodAR, prodBR;

  always_comb begin
    prodAR = ext(sin3) * ext(dRef3);
    prodBR = -(ext(cos3) * ext(dRef3));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alphaR4 <= '0; betaR4 <= '0;
    end else if (stageEn.s4) begin
      alphaR4 <= sat(prodAR >>> FRAC);
      betaR4  <= sat(prodBR >>> FRAC);
    end
  end

  // stage 5: back to three phases
  sample_t refA5, refB5, refC5;
  acc_t accA, accB, accC;

  always_comb begin
    accA = ext(alphaR4) * K_FULL;
    accB = ext(betaR4) * K_ROOT - ext(alphaR4) * K_HALF;
    accC = -(ext(alphaR4) * K_HALF) - ext(betaR4) * K_ROOT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refA5 <= '0; refB5 <= '0; refC5 <= '0;
    end else if (stageEn.s5) begin
      refA5 <= sat(accA >>> FRAC);
      refB5 <= sat(accB >>> FRAC);
      refC5 <= sat(accC >>> FRAC);
    end
  end

  // load-sample carry chain, advanced by each stage's enable
  logic [5:1] chainEn;
  assign chainEn = {stageEn.s5, stageEn.s4, stageEn.s3, stageEn.s2, stageEn.s1};

  for (genvar g = 1; g <= 5; g++) begin : gCarry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ldA[g] <= '0; ldB[g] <= '0; ldC[g] <= '0;
      end else if (chainEn[g]) begin
        if (g == 1) begin
          ldA[g] <= loadA; ldB[g] <= loadB; ldC[g] <= loadC;
        end else begin
          ldA[g] <= ldA[g-1]; ldB[g] <= ldB[g-1]; ldC[g] <= ldC[g-1];
        end
      end
    end
  end

  // stage 6: reference minus load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compA <= '0; compB <= '0; compC <= '0;
    end else if (stageEn.s6) begin
      compA <= sat(ext(refA5) - ext(ldA[5]));
      compB <= sat(ext(refB5) - ext(ldB[5]));
      compC <= sat(ext(refC5) - ext(ldC[5]));
    end
  end
endmodule

// File: rtl/harmRefTop.sv
module harmRefTop
  import harmRefPkg::*;
#(
  parameter int SHIFT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleStrobe,
  input  logic signed [15:0]  loadA,
  input  logic signed [15:0]  loadB,
  input  logic signed [15:0]  loadC,
  input  logic signed [15:0]  sinTheta,
  input  logic signed [15:0]  cosTheta,
  input  logic signed [15:0]  lossCur,
  input  logic [SHIFT_W-1:0]  filtShift,
  output logic                outValid,
  output logic signed [15:0]  compA,
  output logic signed [15:0]  compB,
  output logic signed [15:0]  compC
);
  stageEn_t stageEn;

  harmRefCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .stageEn      (stageEn),
    .outValid     (outValid)
  );

  harmRefDatapath #(.SHIFT_W(SHIFT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stageEn   (stageEn),
    .loadA     (loadA),
    .loadB     (loadB),
    .loadC     (loadC),
    .sinTheta  (sinTheta),
    .cosTheta  (cosTheta),
    .lossCur   (lossCur),
    .filtShift (filtShift),
    .compA     (compA),
    .compB     (compB),
    .compC     (compC)
  );
endmodule

// File: rtl/harmRefChecker.sv
module harmRefChecker
  import harmRefPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sampleStrobe,
  input logic              outValid,
  input logic signed [15:0] compA,
  input logic signed [15:0] compB,
  input logic signed [15:0] compC
);
  logic [3:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + 4'(sampleStrobe) - 4'(outValid);
  end

  // R1: reset holds the outputs at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |-> (!outValid && compA == 0 && compB == 0 && compC == 0));

  // R2: each strobe gives a pulse six edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> ##6 outValid);

  // R2: no pulse without a sample in flight
  p_no_orphan_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inFlight != 0));

  // R2: occupancy never exceeds the pipeline depth
  p_depth_r2: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 4'(STAGES));

  // R11: outputs frozen between valid pulses
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(compA) && $stable(compB) && $stable(compC)));
endmodule

bind harmRefTop harmRefChecker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .sampleStrobe (sampleStrobe),
  .outValid     (outValid),
  .compA        (compA),
  .compB        (compB),
  .compC        (compC)
);

// File: tb/tb_harmRefTop.sv
module tb_harmRefTop;
  logic clk = 0;
  logic rstN = 0;
  logic sampleStrobe = 0;
  logic signed [15:0] loadA = 0, loadB = 0, loadC = 0;
  logic signed [15:0] sinTheta = 0, cosTheta = 0, lossCur = 0;
  logic [3:0] filtShift = 0;
  logic outValid;
  logic signed [15:0] compA, compB, compC;

  int nChecks = 0;
  int nFail = 0;
  int yM = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  harmRefTop dut (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
    .loadA(loadA), .loadB(loadB), .loadC(loadC),
    .sinTheta(sinTheta), .cosTheta(cosTheta), .lossCur(lossCur),
    .filtShift(filtShift), .outValid(outValid),
    .compA(compA), .compB(compB), .compC(compC)
  );

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // Expected outputs per the requirement equations; advances the model filter.
  task automatic model(input int a, input int b, input int c, input int sn,
                       input int cs, input int ls, input int k,
                       output int ea, output int eb, output int ec);
    longint s2 = 2 * longint'(a) - b - c;
    int al = sat((s2 * 26755) >>> 16);
    int be = sat(((longint'(b) - c) * 23170) >>> 15);
    int dd = sat((longint'(sn) * al - longint'(cs) * be) >>> 15);
    longint df = longint'(dd) - yM;
    int dr, ar, br, ra, rb, rc;
    yM = sat(longint'(yM) + (df >>> k));
    dr = sat(longint'(yM) + ls);
    ar = sat((longint'(sn) * dr) >>> 15);
    br = sat((-(longint'(cs) * dr)) >>> 15);
    ra = sat((longint'(ar) * 26755) >>> 15);
    rb = sat((longint'(br) * 23170 - longint'(ar) * 13378) >>> 15);
    rc = sat((-(longint'(ar) * 13378) - longint'(br) * 23170) >>> 15);
    ea = sat(longint'(ra) - a);
    eb = sat(longint'(rb) - b);
    ec = sat(longint'(rc) - c);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input int c, input int sn,
                       input int cs, input int ls, input int k);
    sampleStrobe = 1;
    loadA = 16'(a); loadB = 16'(b); loadC = 16'(c);
    sinTheta = 16'(sn); cosTheta = 16'(cs); lossCur = 16'(ls);
    filtShift = 4'(k);
  endtask

  task automatic runOne(input string req, input int a, input int b, input int c,
                        input int sn, input int cs, input int ls, input int k);
    int ea, eb, ec;
    @(negedge clk);
    drive(a, b, c, sn, cs, ls, k);
    model(a, b, c, sn, cs, ls, k, ea, eb, ec);
    @(negedge clk);
    sampleStrobe = 0;
    repeat (4) @(negedge clk);
    check("R2", "valid early", int'(outValid), 0);
    @(negedge clk);
    check("R2", "valid at latency", int'(outValid), 1);
    check(req, "compA", int'(compA), ea);
    check(req, "compB", int'(compB), eb);
    check(req, "compC", int'(compC), ec);
  endtask

  task automatic rnd16(output int v);
    v = int'($signed(16'($urandom)));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    int a, b, c, sn, cs, ls, hA, hB, hC;
    int qa [5];
    int qb [5];
    int qc [5];
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", int'(outValid), 0);
    check("R1", "compA in reset", int'(compA), 0);
    check("R1", "compB in reset", int'(compB), 0);
    check("R1", "compC in reset", int'(compC), 0);
    rstN = 1;

    // R4 / R9 / R8: k=0 directed samples
    runOne("R4", 8000, -4000, -4000, 32767, 0, 0, 0);
    runOne("R9", 3000, 1200, -9000, 0, 32767, 0, 0);
    runOne("R8", -6000, 7000, 2500, 23170, 23170, 0, 0);
    // R6: loss term offsets the direct-axis reference
    runOne("R6", 0, 0, 0, 32767, 0, 5000, 0);
    runOne("R6", 1000, -500, -500, 0, -32768, -7000, 2);
    // R7: inverse rotation with negative sine and cosine
    runOne("R7", 12000, -3000, -9000, -23170, -23170, 1500, 1);

    // R3: random patterns with assorted shifts
    for (int i = 0; i < 30; i++) begin
      rnd16(a); rnd16(b); rnd16(c); rnd16(sn); rnd16(cs); rnd16(ls);
      runOne("R3", a, b, c, sn, cs, ls >>> 2, int'($urandom_range(0, 6)));
    end

    // R10: extremes that saturate projection, loss sum and output difference
    runOne("R10", 32767, -32768, -32768, 32767, -32768, 32767, 0);
    runOne("R10", -32768, 32767, 32767, -32768, 32767, -32768, 0);
    runOne("R10", 32767, 32767, -32768, 32767, 32767, 32767, 0);

    // R5: slow filter, state moves by small steps across samples
    for (int i = 0; i < 4; i++) runOne("R5", 20000, -10000, -10000, 32767, 0, 0, 15);
    runOne("R5", 20000, -10000, -10000, 32767, 0, 0, 3);

    // R11: inputs toggling without strobe leave outputs and filter untouched
    hA = int'(compA); hB = int'(compB); hC = int'(compC);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rnd16(a); rnd16(b); rnd16(c);
      loadA = 16'(a); loadB = 16'(b); loadC = 16'(c);
      sinTheta = 16'(a ^ b); cosTheta = 16'(c); lossCur = 16'(b);
      filtShift = 4'($urandom_range(0, 15));
    end
    @(negedge clk);
    check("R11", "valid idle", int'(outValid), 0);
    check("R11", "compA hold", int'(compA), hA);
    check("R11", "compB hold", int'(compB), hB);
    check("R11", "compC hold", int'(compC), hC);
    runOne("R11", -2000, 4000, -2000, 32767, 0, 0, 2);

    // R2: back-to-back burst keeps order and spacing
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rnd16(a); rnd16(b); rnd16(c); rnd16(sn); rnd16(cs);
      drive(a, b, c, sn, cs, 100 * i, i);
      model(a, b, c, sn, cs, 100 * i, i, qa[i], qb[i], qc[i]);
    end
    @(negedge clk);
    sampleStrobe = 0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check("R2", "burst valid", int'(outValid), 1);
      check("R2", "burst compA", int'(compA), qa[j]);
      check("R2", "burst compB", int'(compB), qb[j]);
      check("R2", "burst compC", int'(compC), qc[j]);
    end
    @(negedge clk);
    check("R2", "burst end valid", int'(outValid), 0);

    // R1: mid-run reset clears outputs and filter state
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    check("R1", "compA after reset", int'(compA), 0);
    check("R1", "valid after reset", int'(outValid), 0);
    rstN = 1;
    yM = 0;
    runOne("R1", 16000, -8000, -8000, 32767, 0, 0, 1);

    repeat (3) @(negedge clk);
    finish();
  end
endmodule